// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This unit sits between the event sources of a 16-bit processor core and its instruction sequencer. At each instruction boundary it looks at the pending events and picks one to serve. The events are a synchronous exception or software-interrupt request that carries its own type, an edge-triggered non-maskable input, a level maskable input gated by the interrupt-enable flag, and the single-step trap. It then works out the 8-bit vector type. For a maskable request it first runs an acknowledge handshake to learn the type from an external controller.

With the type known, the unit reads the service-routine pointer from the vector table at the bottom of memory. Each entry is four bytes at type times four. The unit makes two 16-bit reads over a request/valid handshake, offset word first and segment word second. It then presents the 32-bit pointer with a one-cycle done pulse. It also owns the interrupt-enable and trap flags, and it tracks the blocking state that follows a non-maskable entry. The sequencer sees a one-cycle push strobe when an entry is accepted, and it drives a return strobe when a handler returns.

Top module: `irq_vector_unit`

## Requirements
- R1: Requests are sampled only on a cycle with `boundary_i` high while the unit is idle. Priority is exception, then non-maskable, then maskable, then single-step.
- R2: A rising edge on `nmi_i` makes a non-maskable request pending. It is served with type 02h, and no acknowledge handshake takes place (`ack_req_o` stays low).
- R3: `intr_i` is taken only when the interrupt-enable flag is 1. Its type is the value on `ack_type_i` in the cycle where `ack_valid_i` answers `ack_req_o`.
- R4: Accepting any event saves the interrupt-enable and trap flags and then clears both. A pulse on `iret_i` restores the saved values. A pulse on `flag_wr_i` loads `flag_if_i` and `flag_tf_i`.
- R5: After a non-maskable entry, both maskable and non-maskable requests are refused until `iret_i` or reset. A rising edge on `nmi_i` that arrives while blocked stays pending and is served at the first boundary after the return. Reset clears the blocking state.
- R6: The first table read is at byte address type×4 and the second at type×4+2, zero-extended to `ADDR_W`. Address and request hold steady until `rd_valid_i`.
- R7: One cycle after the second read completes, `vec_done_o` pulses for exactly one cycle. At the same time `vec_ptr_o` shows {segment word, offset word} and `vec_type_o` shows the served type.
- R8: When the trap flag is 1 and no other event is taken at a boundary, a type 01h event is served.
- R9: Exception and software requests pass their type through unchanged over the full range 00h to FFh, with no acknowledge handshake.
- R10: After reset both flags are 0, nothing is pending or blocked, and every request and strobe output is low.
- R11: `push_o` is high for exactly the one cycle after an event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary sample strobe |
| exc_req_i | input | 1 | Exception or software-interrupt request |
| exc_type_i | input | 8 | Type for the exception/software request |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable request level |
| iret_i | input | 1 | Interrupt-return strobe |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_if_i | input | 1 | Interrupt-enable value to write |
| flag_tf_i | input | 1 | Trap value to write |
| ack_req_o | output | 1 | Acknowledge handshake needed to get the type |
| ack_valid_i | input | 1 | Acknowledge answer valid |
| ack_type_i | input | 8 | Type returned by the interrupt controller |
| rd_req_o | output | 1 | Vector-table read request |
| rd_addr_o | output | ADDR_W | Byte address of the word to read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Read data word |
| vec_done_o | output | 1 | Pointer ready pulse |
| vec_type_o | output | 8 | Type of the served event |
| vec_ptr_o | output | 32 | Segment (upper half) and offset (lower half) |
| push_o | output | 1 | Entry-accepted strobe for the stack sequencer |
| busy_o | output | 1 | An event is being vectored |
| if_o | output | 1 | Interrupt-enable flag |
| tf_o | output | 1 | Trap flag |

## Verification
The embedded properties check, on every cycle, the rules that can be seen locally. Only one of acknowledge, read and done is active at a time. The done and push strobes last one cycle. A non-maskable entry goes straight to a table read. A read request holds its address until answered. Entry clears both flags, and blocking and a pending edge persist until they are consumed or cleared. The bench scenarios show the effects that span whole services. These are the priority outcome when several sources are active together, a refused request while blocked, an edge queued behind the block and served after the return, reset removing the block, flags coming back on return, and the exact pointer assembled from the words read back.

// File: rtl/irq_vec_pkg.sv
// Shared constants and types for the interrupt vectoring unit.
// Assumes byte-addressed vector table at address zero, four bytes per entry.
package irq_vec_pkg;
    localparam int TYPE_W = 8;
    localparam int HALF_W = 16;
    localparam logic [TYPE_W-1:0] NMI_TYPE  = 8'h02;
    localparam logic [TYPE_W-1:0] STEP_TYPE = 8'h01;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_EXC, SRC_NMI, SRC_INTR, SRC_STEP
    } irq_src_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACK, ST_RD_LO, ST_RD_HI, ST_DONE
    } seq_state_e;
endpackage

// File: rtl/irq_nmi_track.sv
// Non-maskable input tracking: rising-edge detection, a pending latch and
// the blocking state that follows a non-maskable entry.
// Assumes nmi_i is already synchronous to clk.
module irq_nmi_track (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic take_nmi_i,
    input  logic iret_i,
    output logic pend_o,
    output logic blocked_o
);
    logic nmi_q, pend_q, blk_q;

    // edge detect, pending latch, block until return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
            blk_q  <= 1'b0;
        end else begin
            nmi_q  <= nmi_i;
            pend_q <= (pend_q & ~take_nmi_i) | (nmi_i & ~nmi_q);
            if (take_nmi_i)  blk_q <= 1'b1;
            else if (iret_i) blk_q <= 1'b0;
        end
    end

    assign pend_o    = pend_q;
    assign blocked_o = blk_q;

    // R5: block persists until a return strobe
    p_block_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q && !iret_i) |=> blk_q);
    // R5: a pending edge is kept until it is served
    p_pend_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take_nmi_i) |=> pend_q);
endmodule

// File: rtl/irq_flag_regs.sv
// Interrupt-enable and trap flags with a single saved copy for entry/return.
// Assumes one level of saving; deeper nesting is held by the stack elsewhere.
module irq_flag_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic iret_i,
    input  logic wr_i,
    input  logic wr_if_i,
    input  logic wr_tf_i,
    output logic if_o,
    output logic tf_o
);
    logic if_q, tf_q, sv_if_q, sv_tf_q;

    // entry saves and clears, return restores, write loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q    <= 1'b0;
            tf_q    <= 1'b0;
            sv_if_q <= 1'b0;
            sv_tf_q <= 1'b0;
        end else if (enter_i) begin
            sv_if_q <= if_q;
            sv_tf_q <= tf_q;
            if_q    <= 1'b0;
            tf_q    <= 1'b0;
        end else if (iret_i) begin
            if_q <= sv_if_q;
            tf_q <= sv_tf_q;
        end else if (wr_i) begin
            if_q <= wr_if_i;
            tf_q <= wr_tf_i;
        end
    end

    assign if_o = if_q;
    assign tf_o = tf_q;

    // R4: entry leaves both flags clear
    p_entry_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> (!if_q && !tf_q));
    // R4: return brings back what entry saved
    p_iret_restores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_i && !enter_i) |=> (if_q == $past(sv_if_q) && tf_q == $past(sv_tf_q)));
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority choice among the four event classes.
// Purely combinational; the caller qualifies the result with the boundary strobe.
module irq_arbiter
    import irq_vec_pkg::*;
(
    input  logic              exc_req_i,
    input  logic [TYPE_W-1:0] exc_type_i,
    input  logic              nmi_pend_i,
    input  logic              blocked_i,
    input  logic              intr_i,
    input  logic              if_i,
    input  logic              tf_i,
    output irq_src_e          src_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              need_ack_o
);
    // exception > non-maskable > maskable > single-step
    always_comb begin
        src_o      = SRC_NONE;
        type_o     = '0;
        need_ack_o = 1'b0;
        if (exc_req_i) begin
            src_o  = SRC_EXC;
            type_o = exc_type_i;
        end else if (nmi_pend_i && !blocked_i) begin
            src_o  = SRC_NMI;
            type_o = NMI_TYPE;
        end else if (intr_i && if_i && !blocked_i) begin
            src_o      = SRC_INTR;
            need_ack_o = 1'b1;
        end else if (tf_i) begin
            src_o  = SRC_STEP;
            type_o = STEP_TYPE;
        end
    end
endmodule

// File: rtl/irq_fetch_seq.sv
// Vector sequencer: optional acknowledge handshake for the type, then two
// table reads (offset word, then segment word), then a one-cycle done state.
// Assumes ADDR_W >= TYPE_W + 2 and a table based at address zero.
module irq_fetch_seq
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TYPE_W-1:0] start_type_i,
    input  logic              start_ack_i,
    input  logic              ack_valid_i,
    input  logic [TYPE_W-1:0] ack_type_i,
    input  logic              rd_valid_i,
    input  logic [HALF_W-1:0] rd_data_i,
    output logic              idle_o,
    output logic              ack_req_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              done_o,
    output logic [2*HALF_W-1:0] ptr_o,
    output logic [TYPE_W-1:0] type_o
);
    localparam int PAD_W = ADDR_W - TYPE_W - 2;

    seq_state_e        state_q;
    logic [TYPE_W-1:0] type_q;
    logic [HALF_W-1:0] off_q, seg_q;

    // state walk and capture of type, offset and segment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            type_q  <= '0;
            off_q   <= '0;
            seg_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    type_q  <= start_type_i;
                    state_q <= start_ack_i ? ST_ACK : ST_RD_LO;
                end
                ST_ACK: if (ack_valid_i) begin
                    type_q  <= ack_type_i;
                    state_q <= ST_RD_LO;
                end
                ST_RD_LO: if (rd_valid_i) begin
                    off_q   <= rd_data_i;
                    state_q <= ST_RD_HI;
                end
                ST_RD_HI: if (rd_valid_i) begin
                    seg_q   <= rd_data_i;
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle_o    = (state_q == ST_IDLE);
    assign ack_req_o = (state_q == ST_ACK);
    assign rd_req_o  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
    assign rd_addr_o = {{PAD_W{1'b0}}, type_q, (state_q == ST_RD_HI), 1'b0};
    assign done_o    = (state_q == ST_DONE);
    assign ptr_o     = {seg_q, off_q};
    assign type_o    = type_q;

    // R6: an unanswered read keeps its request and address
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));
endmodule

// File: rtl/irq_vector_unit.sv
// Interrupt arbitration and vectoring unit (top).
// Samples events at instruction boundaries, picks one by priority, obtains
// the type and fetches the 32-bit service pointer from the vector table.
// Assumes all inputs are synchronous to clk.
module irq_vector_unit
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              exc_req_i,
    input  logic [7:0]        exc_type_i,
    input  logic              nmi_i,
    input  logic              intr_i,
    input  logic              iret_i,
    input  logic              flag_wr_i,
    input  logic              flag_if_i,
    input  logic              flag_tf_i,
    output logic              ack_req_o,
    input  logic              ack_valid_i,
    input  logic [7:0]        ack_type_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [15:0]       rd_data_i,
    output logic              vec_done_o,
    output logic [7:0]        vec_type_o,
    output logic [31:0]       vec_ptr_o,
    output logic              push_o,
    output logic              busy_o,
    output logic              if_o,
    output logic              tf_o
);
    irq_src_e          src;
    logic [TYPE_W-1:0] arb_type;
    logic              need_ack, nmi_pend, blocked, idle, accept, take_nmi;
    logic              push_q;

    assign accept   = boundary_i && idle && (src != SRC_NONE);
    assign take_nmi = accept && (src == SRC_NMI);

    irq_nmi_track u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .take_nmi_i(take_nmi),
        .iret_i(iret_i), .pend_o(nmi_pend), .blocked_o(blocked)
    );

    irq_flag_regs u_flags (
        .clk(clk), .rst_n(rst_n), .enter_i(accept), .iret_i(iret_i),
        .wr_i(flag_wr_i), .wr_if_i(flag_if_i), .wr_tf_i(flag_tf_i),
        .if_o(if_o), .tf_o(tf_o)
    );

    irq_arbiter u_arb (
        .exc_req_i(exc_req_i), .exc_type_i(exc_type_i), .nmi_pend_i(nmi_pend),
        .blocked_i(blocked), .intr_i(intr_i), .if_i(if_o), .tf_i(tf_o),
        .src_o(src), .type_o(arb_type), .need_ack_o(need_ack)
    );

    irq_fetch_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .start_type_i(arb_type),
        .start_ack_i(need_ack), .ack_valid_i(ack_valid_i), .ack_type_i(ack_type_i),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .idle_o(idle),
        .ack_req_o(ack_req_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .done_o(vec_done_o), .ptr_o(vec_ptr_o), .type_o(vec_type_o)
    );

    // one-cycle strobe to the stack sequencer on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) push_q <= 1'b0;
        else        push_q <= accept;
    end

    assign push_o = push_q;
    assign busy_o = !idle;

    // R7: handshake phases never overlap
    p_phase_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_req_o, rd_req_o, vec_done_o}));
    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done_o |=> !vec_done_o);
    // R11: push strobe is a single-cycle pulse
    p_push_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);
    // R2: non-maskable entry goes straight to the table read
    p_nmi_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (!ack_req_o && rd_req_o));
endmodule

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;
    localparam int ADDR_W = 20;

    typedef struct packed {
        logic       exc;
        logic [7:0] exc_type;
        logic       nmi;
        logic       intr;
        logic       ifv;
        logic       tfv;
        logic [7:0] ack_type;
        logic [7:0] exp_type;
        logic       exp_ack;
    } vec_t;

    // exc, exc_type, nmi, intr, IF, TF, ack_type, expected type, expect ack
    localparam vec_t TBL [8] = '{
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
        '{1'b1, 8'h0D, 1'b0, 1'b1, 1'b1, 1'b1, 8'h55, 8'h0D, 1'b0},
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h66, 8'h02, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h20, 8'h20, 1'b1},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h77, 8'h01, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h08, 8'h08, 1'b1},
        '{1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h01, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary_i = 0, exc_req_i = 0, nmi_i = 0, intr_i = 0, iret_i = 0;
    logic flag_wr_i = 0, flag_if_i = 0, flag_tf_i = 0;
    logic [7:0] exc_type_i = '0, ack_type_i = '0;
    logic ack_valid_i = 0, rd_valid_i = 0;
    logic [15:0] rd_data_i = '0;
    logic ack_req_o, rd_req_o, vec_done_o, push_o, busy_o, if_o, tf_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic [7:0] vec_type_o;
    logic [31:0] vec_ptr_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_vector_unit #(.ADDR_W(ADDR_W)) i_irq_vector_unit (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .exc_req_i(exc_req_i),
        .exc_type_i(exc_type_i), .nmi_i(nmi_i), .intr_i(intr_i), .iret_i(iret_i),
        .flag_wr_i(flag_wr_i), .flag_if_i(flag_if_i), .flag_tf_i(flag_tf_i),
        .ack_req_o(ack_req_o), .ack_valid_i(ack_valid_i), .ack_type_i(ack_type_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .vec_done_o(vec_done_o), .vec_type_o(vec_type_o),
        .vec_ptr_o(vec_ptr_o), .push_o(push_o), .busy_o(busy_o), .if_o(if_o), .tf_o(tf_o)
    );

    function automatic logic [15:0] memw(input logic [ADDR_W-1:0] a);
        return 16'(a[15:0] * 16'h0135 + 16'h7A01);
    endfunction

    function automatic logic [ADDR_W-1:0] tbl_addr(input logic [7:0] t, input bit hi);
        return ADDR_W'({t, hi, 1'b0});
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_flags(input logic fi, input logic ft);
        @(negedge clk);
        flag_wr_i = 1; flag_if_i = fi; flag_tf_i = ft;
        @(negedge clk);
        flag_wr_i = 0;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_i = 1;
        @(negedge clk); nmi_i = 0;
    endtask

    task automatic do_iret();
        @(negedge clk); iret_i = 1;
        @(negedge clk); iret_i = 0;
    endtask

    // R1 R11: boundary strobe; accepted entry shows push and busy next cycle
    task automatic launch(input bit exp_acc, input string tag);
        @(negedge clk); boundary_i = 1;
        @(negedge clk); boundary_i = 0;
        check_eq({tag, " R11 push"}, 32'(push_o), 32'(exp_acc));
        check_eq({tag, " R1 busy"}, 32'(busy_o), 32'(exp_acc));
    endtask

    // R2 R3 R6 R7: answer handshakes and check addresses, pointer and type
    task automatic service(input logic [7:0] exp_type, input bit exp_ack,
                           input logic [7:0] ack_t, input string tag);
        bit got_ack = 0;
        bit done = 0;
        int k = 0;
        for (int n = 0; n < 40 && !done; n++) begin
            ack_valid_i = 0; rd_valid_i = 0;
            if (ack_req_o) begin
                got_ack = 1; ack_valid_i = 1; ack_type_i = ack_t;
            end
            if (rd_req_o) begin
                check_eq({tag, " R6 addr"}, 32'(rd_addr_o), 32'(tbl_addr(exp_type, k != 0)));
                rd_valid_i = 1; rd_data_i = memw(rd_addr_o); k++;
            end
            if (vec_done_o) begin
                done = 1;
                check_eq({tag, " R7 ptr"}, vec_ptr_o,
                         {memw(tbl_addr(exp_type, 1)), memw(tbl_addr(exp_type, 0))});
                check_eq({tag, " R7 type"}, 32'(vec_type_o), 32'(exp_type));
                check_eq({tag, " R2 R3 ack"}, 32'(got_ack), 32'(exp_ack));
                check_eq({tag, " R6 reads"}, 32'(k), 32'd2);
            end
            if (!done) @(negedge clk);
        end
        ack_valid_i = 0; rd_valid_i = 0;
        check_eq({tag, " R7 completed"}, 32'(done), 32'd1);
        @(negedge clk);
        check_eq({tag, " R7 single pulse"}, 32'(vec_done_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check_eq("R10 if", 32'(if_o), 0);
        check_eq("R10 tf", 32'(tf_o), 0);
        check_eq("R10 busy", 32'(busy_o), 0);
        check_eq("R10 outs", {28'd0, ack_req_o, rd_req_o, vec_done_o, push_o}, 0);

        // R4: flag write path
        write_flags(1, 1);
        check_eq("R4 write if", 32'(if_o), 1);
        check_eq("R4 write tf", 32'(tf_o), 1);
        write_flags(0, 0);

        // table walk: R1 priority, R3 masking, R8 step, R9 full type range
        foreach (TBL[i]) begin
            string tag;
            tag = $sformatf("R1 R8 R9 vec%0d", i);
            write_flags(TBL[i].ifv, TBL[i].tfv);
            if (TBL[i].nmi) pulse_nmi();
            intr_i = TBL[i].intr;
            exc_req_i = TBL[i].exc;
            exc_type_i = TBL[i].exc_type;
            launch(1, tag);
            service(TBL[i].exp_type, TBL[i].exp_ack, TBL[i].ack_type, tag);
            check_eq({tag, " R4 if cleared"}, 32'(if_o), 0);
            check_eq({tag, " R4 tf cleared"}, 32'(tf_o), 0);
            intr_i = 0; exc_req_i = 0;
            do_iret();
            check_eq({tag, " R4 if restored"}, 32'(if_o), 32'(TBL[i].ifv));
            check_eq({tag, " R4 tf restored"}, 32'(tf_o), 32'(TBL[i].tfv));
        end

        // R1: no sampling without a boundary strobe
        write_flags(1, 0);
        intr_i = 1;
        repeat (5) @(negedge clk);
        check_eq("R1 no boundary busy", 32'(busy_o), 0);
        check_eq("R1 no boundary ack", 32'(ack_req_o), 0);
        launch(1, "R1 late");
        service(8'h40, 1, 8'h40, "R3 late");
        intr_i = 0;
        do_iret();

        // R5: blocking after a non-maskable entry, queued edge served after return
        write_flags(0, 0);
        pulse_nmi();
        launch(1, "R5 first");
        service(8'h02, 0, 8'h00, "R2 first");
        write_flags(1, 0);
        intr_i = 1;
        launch(0, "R5 intr blocked");
        intr_i = 0;
        pulse_nmi();
        launch(0, "R5 nmi blocked");
        do_iret();
        check_eq("R5 no auto serve", 32'(busy_o), 0);
        launch(1, "R5 queued");
        service(8'h02, 0, 8'h00, "R5 queued");
        do_iret();
        write_flags(1, 0);
        intr_i = 1;
        launch(1, "R5 unblocked");
        service(8'h21, 1, 8'h21, "R5 unblocked");
        intr_i = 0;
        do_iret();

        // R5: reset removes the block
        pulse_nmi();
        launch(1, "R5 pre-reset");
        service(8'h02, 0, 8'h00, "R5 pre-reset");
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        check_eq("R10 if after reset", 32'(if_o), 0);
        write_flags(1, 0);
        intr_i = 1;
        launch(1, "R5 after reset");
        service(8'h33, 1, 8'h33, "R5 after reset");
        intr_i = 0;
        do_iret();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule